// File: doc/BRIEF.md
# Factorial Coprocessor

A small compute engine that sits behind a 32-bit register strobe interface. The host writes an integer operand into the operand register. The engine then marks itself busy in a status register and multiplies down from the operand to one, performing one multiply per clock. When it finishes, it writes the product back over the operand in the same register and clears the busy flag.

Software either polls the busy flag or sets an interrupt-enable bit in the status register. When that bit is set, the engine emits a one-cycle interrupt request when it finishes. The request carries a source mask that an interrupt-status block shared with other sources can merge.

Arithmetic is 32-bit and wraps modulo 2^32. While a computation runs, the operand register still shows the value that was written. Any new operand written during that time is discarded.

Top module: `factorial_coproc`

## Requirements
- R1: After synchronous active-high reset, the operand register reads 0, the status register reads 0 and `irqReq` is low.
- R2: A write with `size`=4 to offset 0x08 while idle loads the operand and sets status bit 0 (busy), which is visible from the cycle after the write edge.
- R3: A write to offset 0x08 while status bit 0 is set is discarded: the result and the latency are those of the operand already running.
- R4: The result is n·(n-1)·…·1 modulo 2^32, and an operand of 0 gives 1.
- R5: For operand n accepted at clock edge E, busy clears and the result appears at offset 0x08 after edge E+n+1.
- R6: While busy, a read of offset 0x08 returns the operand as written.
- R7: A write to offset 0x20 copies write-data bit 7 into status bit 7 (interrupt enable). Status bit 0 is not writable through offset 0x20, and the other status bits read 0.
- R8: When a computation completes with status bit 7 set, `irqReq` is high for exactly one cycle, in the cycle busy clears, with `irqMask` = 0x00000001. With bit 7 clear there is no request. `irqMask` is 0 whenever `irqReq` is low.
- R9: Writes with `size` other than 4 are ignored. Reads with `size` other than 4, and reads of unmapped offsets, return 0xFFFFFFFF. `rdData` is 0 when `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (combinational read data) |
| addr | input | 8 | Register byte offset |
| size | input | 4 | Access size in bytes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data |
| irqReq | output | 1 | One-cycle interrupt request |
| irqMask | output | 32 | Interrupt source mask, valid with irqReq |

## Verification
The hardest case to reach is a host write that lands in the middle of a running computation. Such a write must change neither the result nor the finishing cycle. The bench starts a long operand, waits a few cycles, writes a different operand, and then checks both the committed product and the exact cycle count against the first operand. A sweep over operands 0 to 13 with alternating interrupt enable, plus one operand past the point where the product wraps to zero, covers the latency formula, the wrap and the conditional interrupt.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam logic [7:0] OPERAND_OFS = 8'h08;
  localparam logic [7:0] STATUS_OFS  = 8'h20;
  localparam int BUSY_BIT  = 0;
  localparam int IRQEN_BIT = 7;
  localparam int FULL_SIZE = 4;

  typedef struct packed {
    logic load;    // capture operand, seed accumulator and counter
    logic step;    // one multiply, counter down by one
    logic commit;  // write accumulator back over operand
  } factCtrl_t;
endpackage

// File: rtl/fact_datapath.sv
module fact_datapath
  import fact_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  factCtrl_t         ctrl,
  input  logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] operand,
  output logic              cntZero
);
  logic [DATA_W-1:0] operandQ;
  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      operandQ <= '0;
      accQ     <= '0;
      cntQ     <= '0;
    end else if (ctrl.load) begin
      operandQ <= loadVal;
      accQ     <= DATA_W'(1);
      cntQ     <= loadVal;
    end else if (ctrl.step) begin
      accQ <= accQ * cntQ;
      cntQ <= cntQ - DATA_W'(1);
    end else if (ctrl.commit) begin
      operandQ <= accQ;
    end
  end

  assign operand = operandQ;
  assign cntZero = (cntQ == '0);
endmodule

// File: rtl/fact_ctrl.sv
module fact_ctrl
  import fact_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              enBit,
  input  logic              cntZero,
  output factCtrl_t         ctrl,
  output logic              busy,
  output logic              irqEn,
  output logic              irqReq
);
  logic busyQ, irqEnQ, irqReqQ;
  logic fullWr;

  assign fullWr = wrEn && (size == SIZE_W'(FULL_SIZE));

  always_comb begin
    ctrl.load   = fullWr && (addr == ADDR_W'(OPERAND_OFS)) && !busyQ;
    ctrl.step   = busyQ && !cntZero;
    ctrl.commit = busyQ && cntZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ   <= 1'b0;
      irqEnQ  <= 1'b0;
      irqReqQ <= 1'b0;
    end else begin
      irqReqQ <= ctrl.commit && irqEnQ;
      if (ctrl.load)
        busyQ <= 1'b1;
      else if (ctrl.commit)
        busyQ <= 1'b0;
      if (fullWr && (addr == ADDR_W'(STATUS_OFS)))
        irqEnQ <= enBit;
    end
  end

  assign busy   = busyQ;
  assign irqEn  = irqEnQ;
  assign irqReq = irqReqQ;
endmodule

// File: rtl/factorial_coproc.sv
module factorial_coproc
  import fact_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq,
  output logic [DATA_W-1:0] irqMask
);
  factCtrl_t         ctrl;
  logic              cntZero, busy, irqEn;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] statusWord;

  fact_ctrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .size(size),
    .enBit(wrData[IRQEN_BIT]), .cntZero(cntZero), .ctrl(ctrl),
    .busy(busy), .irqEn(irqEn), .irqReq(irqReq)
  );

  fact_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .loadVal(wrData),
    .operand(operand), .cntZero(cntZero)
  );

  always_comb begin
    statusWord = '0;
    statusWord[BUSY_BIT]  = busy;
    statusWord[IRQEN_BIT] = irqEn;
  end

  always_comb begin
    if (!rdEn)
      rdData = '0;
    else if (size != SIZE_W'(FULL_SIZE))
      rdData = '1;
    else if (addr == ADDR_W'(OPERAND_OFS))
      rdData = operand;
    else if (addr == ADDR_W'(STATUS_OFS))
      rdData = statusWord;
    else
      rdData = '1;
  end

  assign irqMask = irqReq ? DATA_W'(1) : '0;
endmodule

// File: rtl/fact_chk.sv
module fact_chk
  import fact_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [SIZE_W-1:0] size,
  input logic              busyQ,
  input logic              irqEnQ,
  input logic [DATA_W-1:0] operandQ,
  input logic              irqReq,
  input logic [DATA_W-1:0] irqMask
);
  // R2
  load_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == ADDR_W'(OPERAND_OFS) && size == SIZE_W'(FULL_SIZE) && !busyQ) |=> busyQ);
  // R6
  operand_steady_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busyQ) && busyQ) |-> $stable(operandQ));
  // R7
  busy_not_writable_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == ADDR_W'(STATUS_OFS) && !busyQ) |=> !busyQ);
  // R8
  irq_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> ($fell(busyQ) && irqEnQ && irqMask == DATA_W'(1)));
  // R8
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    irqReq |=> !irqReq);
  // R8
  mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !irqReq |-> (irqMask == '0));
endmodule

bind factorial_coproc fact_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_fact_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .size(size),
  .busyQ(busy), .irqEnQ(irqEn), .operandQ(operand),
  .irqReq(irqReq), .irqMask(irqMask)
);

// File: tb/test_factorial_coproc.sv
`timescale 1ns/1ps
module test_factorial_coproc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  size = 4'd4;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqReq;
  logic [31:0] irqMask;

  int compared = 0, mismatched = 0, irqCount = 0;
  logic [31:0] lastMask = '0;

  always #2 clk = ~clk;

  factorial_coproc i_factorial_coproc (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .size(size),
    .wrData(wrData), .rdData(rdData), .irqReq(irqReq), .irqMask(irqMask)
  );

  always @(negedge clk) if (!rst && irqReq) begin
    irqCount++;
    lastMask = irqMask;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [7:0] a, logic [31:0] d, logic [3:0] s);
    wrEn = 1'b1; addr = a; wrData = d; size = s;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; size = 4'd4;
  endtask

  task automatic doRead(logic [7:0] a, logic [3:0] s, output logic [31:0] v);
    rdEn = 1'b1; addr = a; size = s;
    #0.5;
    v = rdData;
    rdEn = 1'b0; size = 4'd4;
  endtask

  function automatic logic [31:0] factOf(int n);
    logic [31:0] p = 32'd1;
    for (int k = n; k > 0; k--) p = p * 32'(k);
    return p;
  endfunction

  // after doWrite of operand: wait until busy clears, return cycle count
  task automatic waitDone(logic [31:0] opnd, output int cyc);
    logic [31:0] v;
    cyc = 0;
    doRead(8'h20, 4'd4, v);
    while (v[0] && cyc < 1000) begin
      doRead(8'h08, 4'd4, v);
      check("R6", v, opnd);
      @(negedge clk);
      cyc++;
      doRead(8'h20, 4'd4, v);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    int cyc, irqBefore;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    doRead(8'h08, 4'd4, v); check("R1 operand", v, 32'h0);
    doRead(8'h20, 4'd4, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'b0, irqReq}, 32'h0);
    doRead(8'h08, 4'd4, v); rdEn = 1'b0; #0.5; check("R9 rdEn low", rdData, 32'h0);

    // R7 enable bit and non-writable busy
    doWrite(8'h20, 32'hFFFF_FFFF, 4'd4);
    doRead(8'h20, 4'd4, v); check("R7 set", v, 32'h80);
    doWrite(8'h20, 32'h0000_007F, 4'd4);
    doRead(8'h20, 4'd4, v); check("R7 clear", v, 32'h0);

    // R9 size and unmapped accesses
    doWrite(8'h08, 32'd5, 4'd2);
    doRead(8'h20, 4'd4, v); check("R9 narrow write", v, 32'h0);
    doRead(8'h08, 4'd4, v); check("R9 narrow write operand", v, 32'h0);
    doRead(8'h08, 4'd2, v); check("R9 narrow read", v, 32'hFFFF_FFFF);
    doRead(8'h40, 4'd4, v); check("R9 unmapped", v, 32'hFFFF_FFFF);

    // R2 R4 R5 R8 sweep with alternating enable
    for (int n = 0; n <= 13; n++) begin
      doWrite(8'h20, (n % 2) ? 32'h80 : 32'h0, 4'd4);
      irqBefore = irqCount;
      doWrite(8'h08, 32'(n), 4'd4);
      doRead(8'h20, 4'd4, v); check("R2 busy", v, (n % 2) ? 32'h81 : 32'h01);
      waitDone(32'(n), cyc);
      check("R5 latency", 32'(cyc), 32'(n + 1));
      doRead(8'h08, 4'd4, v); check("R4 result", v, factOf(n));
      @(negedge clk);
      check("R8 irq count", 32'(irqCount - irqBefore), (n % 2) ? 32'd1 : 32'd0);
      if (n % 2) check("R8 mask", lastMask, 32'h1);
    end

    // R4 wrap to zero beyond 33
    doWrite(8'h08, 32'd40, 4'd4);
    waitDone(32'd40, cyc);
    check("R5 latency 40", 32'(cyc), 32'd41);
    doRead(8'h08, 4'd4, v); check("R4 wrap", v, factOf(40));

    // R3 write while busy is dropped
    doWrite(8'h20, 32'h80, 4'd4);
    irqBefore = irqCount;
    doWrite(8'h08, 32'd10, 4'd4);
    repeat (3) @(negedge clk);
    doWrite(8'h08, 32'd5, 4'd4);
    doRead(8'h08, 4'd4, v); check("R3 operand kept", v, 32'd10);
    waitDone(32'd10, cyc);
    check("R3 latency", 32'(cyc), 32'd11 - 32'd4);
    doRead(8'h08, 4'd4, v); check("R3 result", v, factOf(10));
    @(negedge clk);
    check("R3 irq count", 32'(irqCount - irqBefore), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule